// File: doc/BRIEF.md
# Composite Sync Vertical Separator

This block recovers the vertical sync interval from a composite sync stream. The stream carries short horizontal pulses on every line and a much longer vertical interval once per frame. The block filters the stream with an up-counter that runs on its own slow clock, which is nominally around 5 MHz and independent of the pixel clock. The output changes level only after the input has stayed at the opposite level for a programmable number of slow-clock periods. Because that number is set larger than the widest horizontal pulse, line sync is removed and only the frame interval reaches the output.

The composite input is brought into the slow domain through a two-flop synchronizer. The 8-bit threshold input is captured into a register on every slow clock. That register holds 0x20 while reset is asserted. The filter is symmetric: the same count is needed to raise the output and to lower it. The input is taken to be already normalized so that sync is active high, and the output idles low.

Top module: `csync_vsep`

## Requirements
- R1: While reset is asserted and after its release, `vsep_out` is 0, and it stays 0 while `csync_in` stays 0.
- R2: A level change on `csync_in` that persists reaches `vsep_out` on the (2+N)-th rising clock edge after the change. N is the effective threshold. Two of those edges are synchronizer stages.
- R3: The run counter restarts whenever the synchronized input equals the output. Two excursions of N-1 cycles each, separated by a single cycle back at the output level, do not change the output.
- R4: From the low state, a high excursion lasting W clocks raises the output if W >= N and is ignored if W < N.
- R5: From the high state, a low excursion lasting W clocks lowers the output if W >= N and is ignored if W < N.
- R6: A threshold value of 0 behaves as 1. The output then follows the input with only the synchronizer delay plus one clock.
- R7: The full 8-bit range is usable: with threshold 255, an excursion of 254 clocks is rejected and one of 255 clocks passes.
- R8: An excursion that passes shows up at the output with exactly its own width W, shifted by N+2 clocks.
- R9: A train of short pulses, each narrower than N, leaves the output unchanged. A following pulse wider than N passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Dedicated slow filter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_in | input | 1 | Composite sync, active high, asynchronous to clk_slow |
| sep_thresh | input | 8 | Persistence count in slow-clock periods (0 is treated as 1) |
| vsep_out | output | 1 | Separated vertical sync, active high |

## Verification
The assertions assume that `sep_thresh` stays constant while a run is being counted. Under that assumption the counter advances by exactly one per cycle and an output toggle always follows a full run. They also assume `csync_in` changes only between clock edges. The bench changes the threshold only after the input has rested at the output level for more than N+2 clocks. It drives every input edge one time unit after a rising clock edge, so every excursion has an exact integer width in clocks.

// File: rtl/csync_vsep.sv
module csync_vsep #(
  parameter int TW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_THRESH  = 32,
  parameter bit IDLE_LEVEL  = 1'b0
) (
  input  logic          clk_slow,
  input  logic          rst_n,
  input  logic          csync_in,
  input  logic [TW-1:0] sep_thresh,
  output logic          vsep_out
);

  localparam logic [TW-1:0] THR_RST = TW'(DEF_THRESH);
  localparam logic [TW-1:0] THR_MIN = TW'(1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [TW-1:0]          thr_q;
  logic [TW-1:0]          run_cnt;
  logic                   vs_q;

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], csync_in};
  end

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) thr_q <= THR_RST;
    else        thr_q <= sep_thresh;
  end

  wire          sync_bit = sync_q[SYNC_STAGES-1];
  wire          differ   = sync_bit != vs_q;
  wire [TW-1:0] thr_eff  = (thr_q == '0) ? THR_MIN : thr_q;
  wire [TW:0]   run_inc  = {1'b0, run_cnt} + 1'b1;
  wire          reached  = run_inc >= {1'b0, thr_eff};

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      vs_q    <= IDLE_LEVEL;
    end else if (!differ) begin
      run_cnt <= '0;
    end else if (reached) begin
      run_cnt <= '0;
      vs_q    <= ~vs_q;
    end else begin
      run_cnt <= run_inc[TW-1:0];
    end
  end

  assign vsep_out = vs_q;

endmodule

module csync_vsep_chk #(
  parameter int TW         = 8,
  parameter bit IDLE_LEVEL = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_bit,
  input logic          vsync,
  input logic [TW-1:0] cnt,
  input logic [TW-1:0] thr_eff
);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> vsync == IDLE_LEVEL);

  p_toggle_after_mismatch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync) |-> $past(sync_bit) != $past(vsync));

  p_match_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_bit == vsync) |=> cnt == '0);

  p_count_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> cnt == $past(cnt) + 1'b1);

  p_toggle_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync) |-> cnt == '0);

  p_toggle_full_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync) |-> ({1'b0, $past(cnt)} + 1'b1) >= {1'b0, $past(thr_eff)});

endmodule

bind csync_vsep csync_vsep_chk #(.TW(TW), .IDLE_LEVEL(IDLE_LEVEL)) u_chk (
  .clk(clk_slow), .rst_n(rst_n), .sync_bit(sync_q[SYNC_STAGES-1]),
  .vsync(vs_q), .cnt(run_cnt), .thr_eff(thr_eff)
);

// File: tb/tb_csync_vsep.sv
module tb_csync_vsep;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csync = 1'b0;
  logic [7:0] thresh = 8'd0;
  logic       vs;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  csync_vsep dut (
    .clk_slow(clk), .rst_n(rst_n), .csync_in(csync),
    .sep_thresh(thresh), .vsep_out(vs)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // excursion of width w away from level lvl, expected to pass iff w >= n
  task automatic excursion(input bit lvl, input int thr, input int w, input string edge_req);
    int n = (thr == 0) ? 1 : thr;
    int first = -1;
    int cnt = 0;
    csync = lvl;
    thresh = 8'(thr);
    repeat (n + 6) @(posedge clk);
    #1;
    chk(vs == lvl, "R2 settle", int'(vs), int'(lvl));
    csync = ~lvl;
    for (int i = 1; i <= w + n + 8; i++) begin
      @(posedge clk);
      #1;
      if (vs != lvl) begin
        cnt++;
        if (first < 0) first = i;
      end
      if (i == w) csync = lvl;
    end
    if (w >= n) begin
      chk(first == n + 2, "R2 latency", first, n + 2);
      chk(cnt == w, {edge_req, " R8 width"}, cnt, w);
    end else begin
      chk(cnt == 0, {edge_req, " rejected"}, cnt, 0);
    end
  endtask

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int thr_list[7] = '{0, 1, 2, 3, 4, 7, 16};
    int hcnt;
    repeat (3) @(posedge clk);
    #1;
    chk(vs == 1'b0, "R1 in reset", int'(vs), 0);
    rst_n = 1'b1;
    repeat (20) begin
      @(posedge clk);
      #1;
      chk(vs == 1'b0, "R1 idle", int'(vs), 0);
    end

    foreach (thr_list[k]) begin
      int n = (thr_list[k] == 0) ? 1 : thr_list[k];
      for (int w = 1; w <= n + 2; w++) begin
        excursion(1'b0, thr_list[k], w, (thr_list[k] == 0) ? "R6" : "R4");
        excursion(1'b1, thr_list[k], w, (thr_list[k] == 0) ? "R6" : "R5");
      end
    end

    excursion(1'b0, 255, 254, "R7");
    excursion(1'b0, 255, 255, "R7");
    excursion(1'b1, 255, 254, "R7");
    excursion(1'b1, 255, 255, "R7");

    // R3: interrupted excursions do not accumulate
    csync = 1'b0;
    thresh = 8'd10;
    repeat (20) @(posedge clk);
    #1;
    hcnt = 0;
    csync = 1'b1;
    for (int i = 1; i <= 40; i++) begin
      @(posedge clk);
      #1;
      if (vs) hcnt++;
      if (i == 9)  csync = 1'b0;
      if (i == 10) csync = 1'b1;
      if (i == 19) csync = 1'b0;
    end
    chk(hcnt == 0, "R3 split run", hcnt, 0);

    // R9: line pulses ignored, frame pulse passes
    thresh = 8'd16;
    repeat (20) @(posedge clk);
    #1;
    hcnt = 0;
    for (int p = 0; p < 10; p++) begin
      csync = 1'b1;
      for (int i = 1; i <= 48; i++) begin
        @(posedge clk);
        #1;
        if (vs) hcnt++;
        if (i == 8) csync = 1'b0;
      end
    end
    chk(hcnt == 0, "R9 line train", hcnt, 0);
    hcnt = 0;
    csync = 1'b1;
    for (int i = 1; i <= 100; i++) begin
      @(posedge clk);
      #1;
      if (vs) hcnt++;
      if (i == 60) csync = 1'b0;
    end
    chk(hcnt == 60, "R9 frame pulse", hcnt, 60);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule